// File: doc/BRIEF.md
# Serial Flash Status and Configuration Register Unit

This block holds the status and configuration registers of a serial NOR flash slave and carries out the commands that read and write them. An SPI front end, which has already shifted the bits in, hands it a decoded opcode strobe at the start of each command and then one strobe per received data byte, while chip select stays asserted. The block keeps two 8-bit status registers, seen as one 16-bit status word, and one 8-bit configuration register. It manages the write-enable latch and applies a fixed mask of writable bit positions. It presents the selected register on a read-data output for as long as a read command stays selected.

Three status bits are not stored. They come live from the array controller: bit 0 is the busy indication, bit 10 is the program or erase failure flag, and bit 15 is the suspend flag. The full status word and the configuration register are also driven out continuously, so that neighbouring logic can decode the protection, quad-enable and mode fields. Non-volatile storage is modelled as ordinary flops.

Top module: `sfsr_unit`

## Requirements
- R1: After reset the stored status bits, the write-enable latch (status bit 1) and the configuration register are all 0, and the read-data output is 0.
- R2: Status bit 0 follows `busy_i`, bit 10 follows `fail_i` and bit 15 follows `susp_i`. A status write never changes these bits.
- R3: Opcode 06h sets the write-enable latch (status bit 1) and opcode 04h clears it. Both opcodes are ignored while `busy_i` is high.
- R4: With the default parameter, opcode 01h takes two data bytes, low register (status bits 7:0) first, and writes both registers together when the second byte arrives. If chip select drops after one byte, nothing changes. Bytes after the second are ignored.
- R5: A status write changes only bits 2 to 7 of the low register and bits 8, 9, 11, 12, 13 and 14 of the word, which gives the writable mask 7BFCh. Every other bit position keeps its value.
- R6: Opcode 31h writes its one data byte, masked, into status bits 7:0 and leaves bits 15:8 unchanged.
- R7: Opcode 11h writes its one data byte into all eight bits of the configuration register.
- R8: A status or configuration write that does not use the volatile path is accepted only while the write-enable latch is 1. When such a write is accepted, the latch clears. Without the latch the write is ignored.
- R9: After opcode 50h, the next status write (01h or 31h) is accepted without the write-enable latch and leaves the latch unchanged. Any other opcode cancels this permission, a configuration write (11h) does not use it, and it lasts for one status write only.
- R10: Any write attempted while `busy_i` is high is ignored and leaves every register and the latch unchanged.
- R11: Opcode 05h selects status bits 7:0, 35h selects status bits 15:8 and 15h selects the configuration register. The selected register stays on `rd_data_o` for every cycle while chip select stays high. `rd_data_o` is 0 once chip select is low.
- R12: With `ONE_BYTE_WRSR` = 1, opcode 01h takes one data byte and writes only status bits 7:0. Later bytes are ignored and bits 15:8 are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Chip select asserted (active high); a command lasts while it is high |
| op_valid_i | input | 1 | Opcode strobe, one cycle at the start of a command |
| op_code_i | input | 8 | Decoded opcode |
| wr_valid_i | input | 1 | Data byte strobe |
| wr_byte_i | input | 8 | Received data byte |
| busy_i | input | 1 | Array controller busy |
| fail_i | input | 1 | Last program/erase failed |
| susp_i | input | 1 | Program/erase suspended |
| rd_data_o | output | 8 | Byte of the selected register for reads |
| stat_o | output | 16 | Full status word |
| cfg_o | output | 8 | Configuration register |

## Verification
The bench builds two copies of the block. One copy uses `ONE_BYTE_WRSR` = 0 and runs the vector table and all directed cases: the two-byte status write, the mask, the latch, the volatile path, the busy lockout and the reads. The second copy uses `ONE_BYTE_WRSR` = 1 and is held idle until its own case. In that case it shows that a one-byte 01h commits only the low register and ignores the bytes that follow, which the default build cannot reach.

// File: rtl/sfsr_pkg.sv
// Shared constants and types for the flash status/configuration register unit.
// Assumes 8-bit command and data bytes delivered by an SPI front end.
package sfsr_pkg;
    localparam int BYTE_W = 8;
    localparam int SR_W   = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] OP_WR_SR    = 8'h01;
    localparam logic [BYTE_W-1:0] OP_WR_SR_LO = 8'h31;
    localparam logic [BYTE_W-1:0] OP_WR_CFG   = 8'h11;
    localparam logic [BYTE_W-1:0] OP_RD_SR_LO = 8'h05;
    localparam logic [BYTE_W-1:0] OP_RD_SR_HI = 8'h35;
    localparam logic [BYTE_W-1:0] OP_RD_CFG   = 8'h15;
    localparam logic [BYTE_W-1:0] OP_WEN_SET  = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WEN_CLR  = 8'h04;
    localparam logic [BYTE_W-1:0] OP_VOL_WEN  = 8'h50;

    // Bit positions the array controller and neighbours depend on
    localparam int BIT_BUSY = 0;
    localparam int BIT_WEN  = 1;
    localparam int BIT_FAIL = 10;
    localparam int BIT_SUSP = 15;

    localparam logic [SR_W-1:0]   SR_WMASK  = 16'h7BFC;
    localparam logic [SR_W-1:0]   SR_LO_SEL = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
    localparam logic [BYTE_W-1:0] CFG_WMASK = 8'hFF;

    typedef enum logic [1:0] {
        RSEL_NONE, RSEL_SR_LO, RSEL_SR_HI, RSEL_CFG
    } rsel_t;

    typedef enum logic [1:0] {
        WT_NONE, WT_SR_BOTH, WT_SR_LO, WT_CFG
    } wtgt_t;

    typedef struct packed {
        logic            commit;
        wtgt_t           tgt;
        logic [SR_W-1:0] data;
    } wr_req_t;
endpackage

// File: rtl/sfsr_cmd_dec.sv
// Command tracker: latches the opcode for the current chip-select period,
// counts data bytes and raises a single-cycle write request on the final
// byte of a write command. Assumes op and byte strobes never coincide.
module sfsr_cmd_dec
    import sfsr_pkg::*;
#(
    parameter bit ONE_BYTE_WRSR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              op_valid_i,
    input  logic [BYTE_W-1:0] op_code_i,
    input  logic              wr_valid_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    output wr_req_t           wr_req_o,
    output logic              wen_set_o,
    output logic              wen_clr_o,
    output logic              vol_set_o,
    output logic              vol_cancel_o,
    output rsel_t             rsel_o
);
    localparam int CNT_W = 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [BYTE_W-1:0] cur_op_q;
    logic              in_cmd_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              op_hit;
    logic              byte_hit;

    assign op_hit   = sel_i && op_valid_i;
    assign byte_hit = sel_i && in_cmd_q && wr_valid_i;

    // Track the active opcode, byte count and read selection per chip select
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_i) begin
            cur_op_q <= '0;
            in_cmd_q <= 1'b0;
            cnt_q    <= '0;
            rsel_o   <= RSEL_NONE;
        end else if (op_valid_i) begin
            cur_op_q <= op_code_i;
            in_cmd_q <= 1'b1;
            cnt_q    <= '0;
            unique case (op_code_i)
                OP_RD_SR_LO: rsel_o <= RSEL_SR_LO;
                OP_RD_SR_HI: rsel_o <= RSEL_SR_HI;
                OP_RD_CFG:   rsel_o <= RSEL_CFG;
                default:     rsel_o <= RSEL_NONE;
            endcase
        end else if (byte_hit && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Single-cycle commands acting at the opcode strobe
    always_comb begin
        wen_set_o    = op_hit && op_code_i == OP_WEN_SET;
        wen_clr_o    = op_hit && op_code_i == OP_WEN_CLR;
        vol_set_o    = op_hit && op_code_i == OP_VOL_WEN;
        vol_cancel_o = op_hit && op_code_i != OP_VOL_WEN &&
                       op_code_i != OP_WR_SR && op_code_i != OP_WR_SR_LO;
    end

    logic            sr_commit;
    wtgt_t           sr_tgt;
    logic [SR_W-1:0] sr_data;

    generate
        if (ONE_BYTE_WRSR) begin : g_wrsr_one
            // One-byte 01h variant: commits the low register on byte 0
            always_comb begin
                sr_commit = byte_hit && cnt_q == '0;
                sr_tgt    = WT_SR_LO;
                sr_data   = {{BYTE_W{1'b0}}, wr_byte_i};
            end
        end else begin : g_wrsr_two
            logic [BYTE_W-1:0] lo_hold_q;
            // Hold the low byte until the high byte arrives
            always_ff @(posedge clk) begin
                if (!rst_n) lo_hold_q <= '0;
                else if (byte_hit && cnt_q == '0) lo_hold_q <= wr_byte_i;
            end
            // Two-byte 01h variant: commits both registers on byte 1
            always_comb begin
                sr_commit = byte_hit && cnt_q == CNT_W'(1);
                sr_tgt    = WT_SR_BOTH;
                sr_data   = {wr_byte_i, lo_hold_q};
            end
        end
    endgenerate

    // Build the write request for the final byte of a write command
    always_comb begin
        wr_req_o = '{commit: 1'b0, tgt: WT_NONE, data: '0};
        unique case (cur_op_q)
            OP_WR_SR: begin
                wr_req_o = '{commit: sr_commit, tgt: sr_tgt, data: sr_data};
            end
            OP_WR_SR_LO: begin
                wr_req_o = '{commit: byte_hit && cnt_q == '0, tgt: WT_SR_LO,
                             data: {{BYTE_W{1'b0}}, wr_byte_i}};
            end
            OP_WR_CFG: begin
                wr_req_o = '{commit: byte_hit && cnt_q == '0, tgt: WT_CFG,
                             data: {{BYTE_W{1'b0}}, wr_byte_i}};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sfsr_regs.sv
// Register storage: writable status bits, configuration register,
// write-enable latch and one-shot volatile-write permission. Applies the
// writable mask and the busy lockout. Live status bits come from inputs.
module sfsr_regs
    import sfsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              fail_i,
    input  logic              susp_i,
    input  wr_req_t           wr_req_i,
    input  logic              wen_set_i,
    input  logic              wen_clr_i,
    input  logic              vol_set_i,
    input  logic              vol_cancel_i,
    output logic [SR_W-1:0]   stat_o,
    output logic [BYTE_W-1:0] cfg_o
);
    logic [SR_W-1:0]   sr_q;
    logic [BYTE_W-1:0] cfg_q;
    logic              wen_q;
    logic              vol_q;

    logic            is_sr;
    logic            vol_path;
    logic            accept;
    logic [SR_W-1:0] sr_mask;

    // Decide whether the pending write is allowed and which bits it may touch
    always_comb begin
        is_sr    = wr_req_i.tgt == WT_SR_BOTH || wr_req_i.tgt == WT_SR_LO;
        vol_path = is_sr && vol_q;
        accept   = wr_req_i.commit && !busy_i && (vol_path || wen_q);
        sr_mask  = (wr_req_i.tgt == WT_SR_LO) ? (SR_WMASK & SR_LO_SEL) : SR_WMASK;
    end

    // Update stored status and configuration bits on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cfg_q <= '0;
        end else if (accept) begin
            if (is_sr) sr_q <= (sr_q & ~sr_mask) | (wr_req_i.data & sr_mask);
            else       cfg_q <= (cfg_q & ~CFG_WMASK) | (wr_req_i.data[BYTE_W-1:0] & CFG_WMASK);
        end
    end

    // Write-enable latch: set/clear commands, auto-clear after a stored write
    always_ff @(posedge clk) begin
        if (!rst_n)                   wen_q <= 1'b0;
        else if (!busy_i && wen_set_i) wen_q <= 1'b1;
        else if (!busy_i && wen_clr_i) wen_q <= 1'b0;
        else if (accept && !vol_path)  wen_q <= 1'b0;
    end

    // One-shot volatile permission, spent by the next status write attempt
    always_ff @(posedge clk) begin
        if (!rst_n)                              vol_q <= 1'b0;
        else if (!busy_i && vol_set_i)           vol_q <= 1'b1;
        else if (vol_cancel_i)                   vol_q <= 1'b0;
        else if (wr_req_i.commit && is_sr)       vol_q <= 1'b0;
    end

    // Compose the status word from stored and live bits
    always_comb begin
        stat_o           = sr_q & SR_WMASK;
        stat_o[BIT_BUSY] = busy_i;
        stat_o[BIT_WEN]  = wen_q;
        stat_o[BIT_FAIL] = fail_i;
        stat_o[BIT_SUSP] = susp_i;
        cfg_o            = cfg_q;
    end
endmodule

// File: rtl/sfsr_unit.sv
// Top of the flash status/configuration register unit. Connects the command
// tracker to the register storage and drives the read-data byte.
// Assumes the SPI front end delivers decoded opcode and byte strobes.
module sfsr_unit
    import sfsr_pkg::*;
#(
    parameter bit ONE_BYTE_WRSR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              op_valid_i,
    input  logic [BYTE_W-1:0] op_code_i,
    input  logic              wr_valid_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic              busy_i,
    input  logic              fail_i,
    input  logic              susp_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic [SR_W-1:0]   stat_o,
    output logic [BYTE_W-1:0] cfg_o
);
    wr_req_t wr_req;
    logic    wen_set, wen_clr, vol_set, vol_cancel;
    rsel_t   rsel;

    sfsr_cmd_dec #(.ONE_BYTE_WRSR(ONE_BYTE_WRSR)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_i        (sel_i),
        .op_valid_i   (op_valid_i),
        .op_code_i    (op_code_i),
        .wr_valid_i   (wr_valid_i),
        .wr_byte_i    (wr_byte_i),
        .wr_req_o     (wr_req),
        .wen_set_o    (wen_set),
        .wen_clr_o    (wen_clr),
        .vol_set_o    (vol_set),
        .vol_cancel_o (vol_cancel),
        .rsel_o       (rsel)
    );

    sfsr_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy_i),
        .fail_i       (fail_i),
        .susp_i       (susp_i),
        .wr_req_i     (wr_req),
        .wen_set_i    (wen_set),
        .wen_clr_i    (wen_clr),
        .vol_set_i    (vol_set),
        .vol_cancel_i (vol_cancel),
        .stat_o       (stat_o),
        .cfg_o        (cfg_o)
    );

    // Present the selected register while a read stays selected
    always_comb begin
        unique case (rsel)
            RSEL_SR_LO: rd_data_o = stat_o[BYTE_W-1:0];
            RSEL_SR_HI: rd_data_o = stat_o[SR_W-1:BYTE_W];
            RSEL_CFG:   rd_data_o = cfg_o;
            default:    rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/sfsr_unit_chk.sv
// Checker for sfsr_unit, attached by bind. Observes ports only.
module sfsr_unit_chk
    import sfsr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sel_i,
    input logic              op_valid_i,
    input logic [BYTE_W-1:0] op_code_i,
    input logic              wr_valid_i,
    input logic              busy_i,
    input logic [BYTE_W-1:0] rd_data_o,
    input logic [SR_W-1:0]   stat_o,
    input logic [BYTE_W-1:0] cfg_o
);
    // R10
    busy_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(cfg_o));

    // R3
    busy_wen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(stat_o[BIT_WEN]));

    // R3
    wen_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o[BIT_WEN]) |-> $past(sel_i && op_valid_i && op_code_i == OP_WEN_SET));

    // R8
    cfg_write_clears_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> !stat_o[BIT_WEN]);

    // R5
    sr_change_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stat_o & SR_WMASK) |-> $past(wr_valid_i && !busy_i));

    // R11
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> rd_data_o == '0);
endmodule

bind sfsr_unit sfsr_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_i),
    .op_valid_i (op_valid_i),
    .op_code_i  (op_code_i),
    .wr_valid_i (wr_valid_i),
    .busy_i     (busy_i),
    .rd_data_o  (rd_data_o),
    .stat_o     (stat_o),
    .cfg_o      (cfg_o)
);

// File: tb/sfsr_unit_tb_top.sv
// Bench for sfsr_unit: table of write vectors, then directed cases.
module sfsr_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, op_valid = 1'b0, wr_valid = 1'b0;
    logic [7:0] op_code = '0, wr_byte = '0;
    logic busy = 1'b0, fail = 1'b0, susp = 1'b0;
    logic en1b = 1'b0;
    logic [7:0]  rd_a, cfg_a, rd_b, cfg_b;
    logic [15:0] stat_a, stat_b;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sfsr_unit #(.ONE_BYTE_WRSR(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_i(sel & ~en1b), .op_valid_i(op_valid & ~en1b),
        .op_code_i(op_code), .wr_valid_i(wr_valid & ~en1b), .wr_byte_i(wr_byte),
        .busy_i(busy), .fail_i(fail), .susp_i(susp),
        .rd_data_o(rd_a), .stat_o(stat_a), .cfg_o(cfg_a));

    sfsr_unit #(.ONE_BYTE_WRSR(1'b1)) dut1b_i (
        .clk(clk), .rst_n(rst_n), .sel_i(sel & en1b), .op_valid_i(op_valid & en1b),
        .op_code_i(op_code), .wr_valid_i(wr_valid & en1b), .wr_byte_i(wr_byte),
        .busy_i(1'b0), .fail_i(1'b0), .susp_i(1'b0),
        .rd_data_o(rd_b), .stat_o(stat_b), .cfg_o(cfg_b));

    // Vector: {wen first, opcode, byte count, byte0, byte1, expected status, expected cfg}
    localparam int NV = 10;
    localparam logic [50:0] VEC [NV] = '{
        {1'b1, 8'h01, 2'd2, 8'hFF, 8'hFF, 16'h7BFC, 8'h00},
        {1'b1, 8'h31, 2'd1, 8'h00, 8'h00, 16'h7B00, 8'h00},
        {1'b0, 8'h01, 2'd2, 8'hFF, 8'hFF, 16'h7B00, 8'h00},
        {1'b1, 8'h11, 2'd1, 8'hA5, 8'h00, 16'h7B00, 8'hA5},
        {1'b1, 8'h01, 2'd2, 8'h54, 8'h22, 16'h2254, 8'hA5},
        {1'b1, 8'h01, 2'd1, 8'hFC, 8'h00, 16'h2256, 8'hA5},
        {1'b0, 8'h04, 2'd0, 8'h00, 8'h00, 16'h2254, 8'hA5},
        {1'b1, 8'h11, 2'd1, 8'h3C, 8'h00, 16'h2254, 8'h3C},
        {1'b0, 8'h06, 2'd0, 8'h00, 8'h00, 16'h2256, 8'h3C},
        {1'b0, 8'h31, 2'd1, 8'hFF, 8'h00, 16'h22FC, 8'h3C}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Full command: opcode, up to three bytes, then chip select low
    task automatic send(input logic [7:0] op, input int n,
                        input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        logic [7:0] bs [3];
        bs[0] = b0; bs[1] = b1; bs[2] = b2;
        @(negedge clk); sel = 1'b1; op_valid = 1'b1; op_code = op;
        @(negedge clk); op_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1; wr_byte = bs[i];
            @(negedge clk);
        end
        wr_valid = 1'b0; sel = 1'b0;
        @(negedge clk);
    endtask

    // Read command held for several cycles, then released
    task automatic read_hold(input string req, input logic [7:0] op, input logic [7:0] exp);
        @(negedge clk); sel = 1'b1; op_valid = 1'b1; op_code = op;
        @(negedge clk); op_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(req, {8'h00, rd_a}, {8'h00, exp});
            @(negedge clk);
        end
        sel = 1'b0;
        @(negedge clk);
        chk(req, {8'h00, rd_a}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", stat_a, 16'h0000);
        chk("R1", {8'h00, cfg_a}, 16'h0000);
        chk("R1", {8'h00, rd_a}, 16'h0000);

        // Vector table: R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][50]) send(8'h06, 0, 8'h00, 8'h00, 8'h00);
            send(VEC[v][49:42], int'(VEC[v][41:40]), VEC[v][39:32], VEC[v][31:24], 8'h00);
            chk("R4/R5/R6/R8 status", stat_a, VEC[v][23:8]);
            chk("R7/R8 cfg", {8'h00, cfg_a}, {8'h00, VEC[v][7:0]});
        end

        // R2 live bits and reads while busy
        busy = 1'b1; fail = 1'b1; susp = 1'b1;
        @(negedge clk);
        chk("R2", stat_a, 16'hA6FD);
        read_hold("R2 lo read", 8'h05, 8'hFD);
        read_hold("R2 hi read", 8'h35, 8'hA6);
        // R3 and R10: latch set ignored while busy, write ignored
        send(8'h06, 0, 8'h00, 8'h00, 8'h00);
        chk("R3", stat_a, 16'hA6FD);
        send(8'h31, 1, 8'h00, 8'h00, 8'h00);
        chk("R10", stat_a, 16'hA6FD);
        busy = 1'b0; fail = 1'b0; susp = 1'b0;
        send(8'h06, 0, 8'h00, 8'h00, 8'h00);
        chk("R3 set", stat_a, 16'h22FE);
        busy = 1'b1;
        send(8'h11, 1, 8'h00, 8'h00, 8'h00);
        send(8'h31, 1, 8'h00, 8'h00, 8'h00);
        chk("R10 status", stat_a, 16'h22FF);
        chk("R10 cfg", {8'h00, cfg_a}, 16'h003C);
        send(8'h04, 0, 8'h00, 8'h00, 8'h00);
        chk("R3 clear ignored busy", stat_a, 16'h22FF);
        busy = 1'b0;
        send(8'h04, 0, 8'h00, 8'h00, 8'h00);
        chk("R3 clear", stat_a, 16'h22FC);

        // R9 volatile path
        send(8'h50, 0, 8'h00, 8'h00, 8'h00);
        send(8'h31, 1, 8'h00, 8'h00, 8'h00);
        chk("R9 accepted", stat_a, 16'h2200);
        send(8'h31, 1, 8'hFC, 8'h00, 8'h00);
        chk("R9 one-shot", stat_a, 16'h2200);
        send(8'h50, 0, 8'h00, 8'h00, 8'h00);
        send(8'h11, 1, 8'h00, 8'h00, 8'h00);
        chk("R9 cfg unaffected", {8'h00, cfg_a}, 16'h003C);

        // R11 reads repeat while selected
        read_hold("R11 cfg", 8'h15, 8'h3C);
        read_hold("R11 hi", 8'h35, 8'h22);

        // R4 extra bytes after the second are ignored
        send(8'h06, 0, 8'h00, 8'h00, 8'h00);
        send(8'h01, 3, 8'h00, 8'h00, 8'hFF);
        chk("R4 extra byte", stat_a, 16'h0000);

        // R12 one-byte variant on the second copy
        en1b = 1'b1;
        send(8'h06, 0, 8'h00, 8'h00, 8'h00);
        send(8'h01, 2, 8'hFF, 8'hFF, 8'h00);
        chk("R12", stat_b, 16'h00FC);
        chk("R12 other copy", stat_a, 16'h0000);
        en1b = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule